// File: doc/BRIEF.md
# Clock Source Switch Controller

This block moves the system clock at run time from the internal oscillator path to a primary external oscillator, optionally followed by a PLL stage. After the select bits ask for the primary source, the core keeps running on the internal clock. Meanwhile a timer in the primary clock domain counts an oscillator start-up period. When the PLL is enabled, the timer then waits a further lock delay. Only when the primary source is declared ready does a glitch-free multiplexer hand the output over. The multiplexer uses break-before-make gating with a two-flop synchroniser in each clock domain.

Completing the handover raises a start-up-done flag and drops the internal-oscillator-stable flags. The controller does not modify the select inputs themselves. A separate enable keeps the low-frequency internal oscillator running whenever the watchdog or the fail-safe monitor needs it.

Top module: `clk_source_switch`

## Requirements
- R1: While reset is active, and after it is released with the internal source selected, `clk_out` follows `clk_int`, `startup_done` is 0, and the stable flag of the chosen internal band is 1.
- R2: After `src_sel` becomes 2'b00 (primary; every other code selects the internal path), `clk_out` keeps following `clk_int` and `startup_done` stays 0 for at least `OST_CYCLES` (default 1024) periods of `clk_pri`.
- R3: With `pll_en` = 0, `startup_done` rises no later than `OST_CYCLES` + 30 primary periods after the request. From then on `clk_out` follows `clk_pri`.
- R4: With `pll_en` = 1, `startup_done` rises no earlier than `OST_CYCLES` + `PLL_LOCK_CYCLES` primary periods after the request, and no later than that sum + 30.
- R5: Once `startup_done` is 1, `hf_stable` and `mf_stable` are both 0.
- R6: In any `clk_int` cycle where `src_sel` is not 2'b00, `startup_done` is 0 from the next cycle on. This includes a deselect that arrives while the handover is in flight: the block then returns to the internal clock without setting the flag.
- R7: If the request is withdrawn during the start-up count and later made again, the count restarts from zero. The new request again needs at least `OST_CYCLES` primary periods.
- R8: No high or low phase of `clk_out` is shorter than the shorter half period of the two source clocks.
- R9: The internal-path and primary-path gate enables are never active together.
- R10: `lf_osc_en` is 1 one `clk_int` cycle after `wdt_en` or `fscm_en` is 1, and 0 one cycle after both are 0.
- R11: While the internal path is in use, `hf_stable` is 1 when `int_band` = 0 and `mf_stable` is 1 when `int_band` = 1. The other flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; also clocks the controller |
| clk_pri | input | 1 | Raw primary oscillator (or PLL output) clock |
| rst | input | 1 | Synchronous active-high reset, seen in both domains |
| src_sel | input | 2 | Source select: 2'b00 primary, others internal |
| pll_en | input | 1 | Adds the PLL lock delay after the start-up count |
| int_band | input | 1 | Internal band in use: 0 high-frequency, 1 mid-frequency |
| wdt_en | input | 1 | Watchdog enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| clk_out | output | 1 | Glitch-free selected system clock |
| startup_done | output | 1 | Primary source is running the system clock |
| hf_stable | output | 1 | High-frequency internal path is stable and in use |
| mf_stable | output | 1 | Mid-frequency internal path is stable and in use |
| lf_osc_en | output | 1 | Keep the low-frequency internal oscillator running |

## Verification
Two events can land in the same controller cycle: the completion of the handover to the primary clock, and the withdrawal of the primary selection. To provoke this, the bench requests the primary source and watches `clk_out`. When `clk_out` shows a low gap longer than either half period, the break-before-make window is open, and the bench drops `src_sel` at once. The run is judged correct if three things hold: `startup_done` never rises, `clk_out` ends up following `clk_int` again with the band flag restored, and the pulse-width monitor finds no runt on `clk_out` through the whole episode.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam logic [1:0] SEL_PRIMARY = 2'b00;

    typedef enum logic [1:0] {
        CS_INTERNAL = 2'd0,
        CS_WAIT     = 2'd1,
        CS_SWAP     = 2'd2,
        CS_PRIMARY  = 2'd3
    } ctrl_state_t;

    typedef enum logic [1:0] {
        TP_IDLE  = 2'd0,
        TP_OST   = 2'd1,
        TP_LOCK  = 2'd2,
        TP_READY = 2'd3
    } timer_phase_t;

    typedef struct packed {
        logic hf;
        logic mf;
    } int_flags_t;

    function automatic logic wants_primary(input logic [1:0] sel);
        return sel == SEL_PRIMARY;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/csw_sync2.sv
module csw_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/csw_startup_timer.sv
module csw_startup_timer
    import csw_pkg::*;
#(
    parameter int OST_CYCLES      = 1024,
    parameter int PLL_LOCK_CYCLES = 1500
) (
    input  logic clk_pri,
    input  logic rst,
    input  logic start_req,
    input  logic pll_en,
    output logic ready
);
    localparam int CNT_W = $clog2(max_u(OST_CYCLES, PLL_LOCK_CYCLES) + 1);

    logic [1:0]   in_s;
    logic         req_s;
    logic         pll_s;
    timer_phase_t phase;
    logic [CNT_W-1:0] cnt;

    csw_sync2 #(.W(2)) u_in_sync (
        .clk (clk_pri),
        .rst (rst),
        .d   ({start_req, pll_en}),
        .q   (in_s)
    );

    assign req_s = in_s[1];
    assign pll_s = in_s[0];

    always_ff @(posedge clk_pri) begin
        if (rst || !req_s) begin
            phase <= TP_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                TP_IDLE: begin
                    phase <= TP_OST;
                    cnt   <= '0;
                end
                TP_OST: begin
                    if (cnt == CNT_W'(OST_CYCLES - 1)) begin
                        cnt   <= '0;
                        phase <= pll_s ? TP_LOCK : TP_READY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TP_LOCK: begin
                    if (cnt == CNT_W'(PLL_LOCK_CYCLES - 1)) begin
                        cnt   <= '0;
                        phase <= TP_READY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= TP_READY;
            endcase
        end
    end

    assign ready = (phase == TP_READY);
endmodule

// File: rtl/csw_glitchfree_mux.sv
module csw_glitchfree_mux (
    input  logic clk_int,
    input  logic clk_pri,
    input  logic rst,
    input  logic want_pri,
    output logic clk_out,
    output logic en_int,
    output logic en_pri
);
    logic int_s1;
    logic pri_s1;

    // Internal side: released only when primary gate is observed closed.
    always_ff @(posedge clk_int) begin
        if (rst) int_s1 <= 1'b1;
        else     int_s1 <= !want_pri && !en_pri;
    end

    always_ff @(negedge clk_int) begin
        if (rst) en_int <= 1'b1;
        else     en_int <= int_s1;
    end

    // Primary side: opens only after the internal gate is closed.
    always_ff @(posedge clk_pri) begin
        if (rst) pri_s1 <= 1'b0;
        else     pri_s1 <= want_pri && !en_int;
    end

    always_ff @(negedge clk_pri) begin
        if (rst) en_pri <= 1'b0;
        else     en_pri <= pri_s1;
    end

    assign clk_out = (clk_int && en_int) || (clk_pri && en_pri);
endmodule

// File: rtl/csw_ctrl.sv
module csw_ctrl
    import csw_pkg::*;
(
    input  logic       clk_int,
    input  logic       rst,
    input  logic [1:0] src_sel,
    input  logic       ready_raw,
    input  logic       en_int,
    input  logic       en_pri_raw,
    input  logic       int_band,
    input  logic       wdt_en,
    input  logic       fscm_en,
    output logic       start_req,
    output logic       want_pri,
    output logic       startup_done,
    output int_flags_t flags,
    output logic       lf_osc_en
);
    ctrl_state_t state, state_nx;
    logic [1:0]  back_s;
    logic        ready_s;
    logic        pri_ack_s;
    logic        sel_pri;

    csw_sync2 #(.W(2)) u_back_sync (
        .clk (clk_int),
        .rst (rst),
        .d   ({ready_raw, en_pri_raw}),
        .q   (back_s)
    );

    assign ready_s   = back_s[1];
    assign pri_ack_s = back_s[0];
    assign sel_pri   = wants_primary(src_sel);

    always_comb begin
        state_nx = state;
        case (state)
            CS_INTERNAL:
                if (sel_pri && en_int && !pri_ack_s && !ready_s) state_nx = CS_WAIT;
            CS_WAIT:
                if (!sel_pri)     state_nx = CS_INTERNAL;
                else if (ready_s) state_nx = CS_SWAP;
            CS_SWAP:
                if (!en_int && pri_ack_s) state_nx = sel_pri ? CS_PRIMARY : CS_INTERNAL;
            CS_PRIMARY:
                if (!sel_pri) state_nx = CS_INTERNAL;
            default: state_nx = CS_INTERNAL;
        endcase
    end

    always_ff @(posedge clk_int) begin
        if (rst) begin
            state     <= CS_INTERNAL;
            lf_osc_en <= 1'b0;
        end else begin
            state     <= state_nx;
            lf_osc_en <= wdt_en || fscm_en;
        end
    end

    assign start_req    = (state != CS_INTERNAL);
    assign want_pri     = (state == CS_SWAP) || (state == CS_PRIMARY);
    assign startup_done = (state == CS_PRIMARY);
    assign flags.hf     = !startup_done && !int_band;
    assign flags.mf     = !startup_done && int_band;
endmodule

// File: rtl/clk_source_switch.sv
module clk_source_switch
    import csw_pkg::*;
#(
    parameter int OST_CYCLES      = 1024,
    parameter int PLL_LOCK_CYCLES = 1500
) (
    input  logic       clk_int,
    input  logic       clk_pri,
    input  logic       rst,
    input  logic [1:0] src_sel,
    input  logic       pll_en,
    input  logic       int_band,
    input  logic       wdt_en,
    input  logic       fscm_en,
    output logic       clk_out,
    output logic       startup_done,
    output logic       hf_stable,
    output logic       mf_stable,
    output logic       lf_osc_en
);
    logic       start_req_w;
    logic       ready_w;
    logic       want_pri_w;
    logic       en_int_w;
    logic       en_pri_w;
    int_flags_t flags_w;

    csw_startup_timer #(
        .OST_CYCLES      (OST_CYCLES),
        .PLL_LOCK_CYCLES (PLL_LOCK_CYCLES)
    ) u_timer (
        .clk_pri   (clk_pri),
        .rst       (rst),
        .start_req (start_req_w),
        .pll_en    (pll_en),
        .ready     (ready_w)
    );

    csw_ctrl u_ctrl (
        .clk_int      (clk_int),
        .rst          (rst),
        .src_sel      (src_sel),
        .ready_raw    (ready_w),
        .en_int       (en_int_w),
        .en_pri_raw   (en_pri_w),
        .int_band     (int_band),
        .wdt_en       (wdt_en),
        .fscm_en      (fscm_en),
        .start_req    (start_req_w),
        .want_pri     (want_pri_w),
        .startup_done (startup_done),
        .flags        (flags_w),
        .lf_osc_en    (lf_osc_en)
    );

    csw_glitchfree_mux u_mux (
        .clk_int  (clk_int),
        .clk_pri  (clk_pri),
        .rst      (rst),
        .want_pri (want_pri_w),
        .clk_out  (clk_out),
        .en_int   (en_int_w),
        .en_pri   (en_pri_w)
    );

    assign hf_stable = flags_w.hf;
    assign mf_stable = flags_w.mf;
endmodule

// File: rtl/csw_checker.sv
module csw_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] src_sel,
    input logic       startup_done,
    input logic       en_int,
    input logic       en_pri,
    input logic       wdt_en,
    input logic       fscm_en,
    input logic       lf_osc_en
);
    // R3: completion implies the mux is gated onto the primary clock only
    p_done_on_primary_r3: assert property (@(posedge clk) disable iff (rst)
        startup_done |-> (en_pri && !en_int));

    // R6: leaving the primary selection clears the flag next cycle
    p_done_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (src_sel != 2'b00) |=> !startup_done);

    // R9: the two gate enables never overlap
    p_break_before_make_r9: assert property (@(posedge clk) disable iff (rst)
        !(en_int && en_pri));

    // R10: low-frequency oscillator kept alive for watchdog or monitor
    p_lf_on_r10: assert property (@(posedge clk) disable iff (rst)
        (wdt_en || fscm_en) |=> lf_osc_en);

    p_lf_off_r10: assert property (@(posedge clk) disable iff (rst)
        (!wdt_en && !fscm_en) |=> !lf_osc_en);
endmodule

bind clk_source_switch csw_checker u_csw_checker (
    .clk          (clk_int),
    .rst          (rst),
    .src_sel      (src_sel),
    .startup_done (startup_done),
    .en_int       (en_int_w),
    .en_pri       (en_pri_w),
    .wdt_en       (wdt_en),
    .fscm_en      (fscm_en),
    .lf_osc_en    (lf_osc_en)
);

// File: tb/test_clk_source_switch.sv
`timescale 1ns/1ps
module test_clk_source_switch;

    localparam int OST  = 1024;
    localparam int LOCK = 1500;
    localparam int SLACK = 30;
    localparam real MIN_PHASE = 2.9;

    logic       clk_int = 1'b0;
    logic       clk_pri = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'b10;
    logic       pll_en = 1'b0;
    logic       int_band = 1'b0;
    logic       wdt_en = 1'b0;
    logic       fscm_en = 1'b0;
    logic       clk_out, startup_done, hf_stable, mf_stable, lf_osc_en;

    int n_checks = 0;
    int n_fail   = 0;
    int pri_cnt  = 0;
    int runts    = 0;
    bit mon_on   = 1'b0;
    realtime last_edge = 0.0;
    realtime last_fall = 0.0;

    clk_source_switch #(.OST_CYCLES(OST), .PLL_LOCK_CYCLES(LOCK)) i_clk_source_switch (
        .clk_int      (clk_int),
        .clk_pri      (clk_pri),
        .rst          (rst),
        .src_sel      (src_sel),
        .pll_en       (pll_en),
        .int_band     (int_band),
        .wdt_en       (wdt_en),
        .fscm_en      (fscm_en),
        .clk_out      (clk_out),
        .startup_done (startup_done),
        .hf_stable    (hf_stable),
        .mf_stable    (mf_stable),
        .lf_osc_en    (lf_osc_en)
    );

    always #4 clk_int = ~clk_int;
    initial begin
        #1.3;
        forever #3 clk_pri = ~clk_pri;
    end
    always @(posedge clk_pri) pri_cnt++;

    // R8 pulse-width monitor on clk_out
    always @(clk_out) begin
        if (mon_on && ($realtime - last_edge) < MIN_PHASE) runts++;
        last_edge = $realtime;
        if (!clk_out) last_fall = $realtime;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // returns number of mismatching samples over 4 periods
    task automatic follows(input bit use_pri, output int bad);
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            if (use_pri) @(posedge clk_pri); else @(posedge clk_int);
            #1;
            if (clk_out !== 1'b1) bad++;
            if (use_pri) @(negedge clk_pri); else @(negedge clk_int);
            #1;
            if (clk_out !== 1'b0) bad++;
        end
    endtask

    task automatic wait_done(input int limit, output int elapsed, input int start);
        elapsed = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk_int);
            if (startup_done) begin
                elapsed = pri_cnt - start;
                break;
            end
        end
    endtask

    task automatic go_internal();
        @(negedge clk_int);
        src_sel = 2'b10;
        repeat (20) @(negedge clk_int);
    endtask

    task automatic t_reset();
        int bad;
        follows(1'b0, bad);
        check(bad == 0, "R1 clk_out follows clk_int in reset", bad, 0);
        check(startup_done == 1'b0, "R1 startup_done in reset", startup_done, 0);
        @(negedge clk_int); rst = 1'b0;
        repeat (5) @(negedge clk_int);
        check(hf_stable == 1'b1 && mf_stable == 1'b0, "R1 band flags after reset",
              {hf_stable, mf_stable}, 2'b10);
        mon_on = 1'b1;
    endtask

    task automatic t_plain_switch();
        int bad, start, el;
        @(negedge clk_int);
        src_sel = 2'b00; start = pri_cnt;
        wait (pri_cnt - start >= OST - 40);
        @(negedge clk_int);
        check(startup_done == 1'b0, "R2 no done during start-up", startup_done, 0);
        follows(1'b0, bad);
        check(bad == 0, "R2 still on clk_int during start-up", bad, 0);
        wait_done(2000, el, start);
        check(el >= OST && el <= OST + SLACK, "R3 handover time window", el, OST);
        follows(1'b1, bad);
        check(bad == 0, "R3 clk_out follows clk_pri", bad, 0);
        check(hf_stable == 1'b0 && mf_stable == 1'b0, "R5 flags cleared on done",
              {hf_stable, mf_stable}, 0);
        @(negedge clk_int); src_sel = 2'b11;
        @(negedge clk_int);
        check(startup_done == 1'b0, "R6 done cleared one cycle after deselect", startup_done, 0);
        repeat (20) @(negedge clk_int);
        follows(1'b0, bad);
        check(bad == 0, "R6 back on clk_int", bad, 0);
        check(hf_stable == 1'b1, "R11 hf flag restored", hf_stable, 1);
    endtask

    task automatic t_pll_switch();
        int start, el;
        @(negedge clk_int);
        pll_en = 1'b1; src_sel = 2'b00; start = pri_cnt;
        wait_done(4000, el, start);
        check(el >= OST + LOCK && el <= OST + LOCK + SLACK, "R4 PLL lock delay window",
              el, OST + LOCK);
        pll_en = 1'b0;
        go_internal();
    endtask

    task automatic t_abort_restart();
        int start, el;
        @(negedge clk_int);
        src_sel = 2'b00;
        wait (pri_cnt - start >= 0);
        start = pri_cnt;
        wait (pri_cnt - start >= 600);
        @(negedge clk_int); src_sel = 2'b01;
        repeat (10) @(negedge clk_int);
        check(startup_done == 1'b0, "R7 withdrawn request leaves done low", startup_done, 0);
        src_sel = 2'b00; start = pri_cnt;
        wait_done(2000, el, start);
        check(el >= OST && el <= OST + SLACK, "R7 count restarted from zero", el, OST);
        go_internal();
    endtask

    task automatic t_collide();
        int bad, start, hits;
        bit gap;
        @(negedge clk_int);
        src_sel = 2'b00; start = pri_cnt;
        gap = 1'b0;
        for (int i = 0; i < 40000 && !gap; i++) begin
            #0.5;
            if (clk_out == 1'b0 && ($realtime - last_fall) > 4.5) gap = 1'b1;
        end
        check(gap, "R6 handover gap observed", gap, 1);
        src_sel = 2'b10;
        hits = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk_int);
            if (startup_done) hits++;
        end
        check(hits == 0, "R6 deselect during handover keeps done low", hits, 0);
        follows(1'b0, bad);
        check(bad == 0, "R6 returned to clk_int after collision", bad, 0);
        check(hf_stable == 1'b1, "R11 hf flag after collision", hf_stable, 1);
    endtask

    task automatic t_band();
        @(negedge clk_int); int_band = 1'b1;
        @(negedge clk_int);
        check(mf_stable == 1'b1 && hf_stable == 1'b0, "R11 mid band flags",
              {hf_stable, mf_stable}, 2'b01);
        int_band = 1'b0;
        @(negedge clk_int);
        check(hf_stable == 1'b1 && mf_stable == 1'b0, "R11 high band flags",
              {hf_stable, mf_stable}, 2'b10);
    endtask

    task automatic t_lfosc();
        @(negedge clk_int); wdt_en = 1'b1;
        @(negedge clk_int);
        check(lf_osc_en == 1'b1, "R10 lf on with watchdog", lf_osc_en, 1);
        wdt_en = 1'b0; fscm_en = 1'b1;
        @(negedge clk_int);
        check(lf_osc_en == 1'b1, "R10 lf on with monitor", lf_osc_en, 1);
        fscm_en = 1'b0;
        @(negedge clk_int);
        check(lf_osc_en == 1'b0, "R10 lf off when both off", lf_osc_en, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #300000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (10) @(negedge clk_int);
        t_reset();
        t_band();
        t_lfosc();
        t_plain_switch();
        t_pll_switch();
        t_abort_restart();
        t_collide();
        check(runts == 0, "R8 no runt pulses on clk_out", runts, 0);
        finish_run();
    end
endmodule